// File: doc/BRIEF.md
# Custom Function Dispatch Unit with Resident-Tag Check

This execute-stage unit serves custom register-to-register instructions. Each such instruction names an 11-bit function number and supplies two source operands; the unit produces one result for the destination register. A small bank of resident slots records which function numbers are currently loaded, together with the built-in datapath operation each one maps to. When the requested number matches a valid slot, the result is computed combinationally and returned in the same cycle. When it does not, the unit raises a miss request instead of quietly executing some other function, and the host pipeline stalls or traps until a reload writes the wanted tag into a slot.

Reloads arrive on a single-cycle write port that carries a tag and an operation select. Slots are replaced in rotating order; the index of the slot the next reload will take is visible on an output. Apart from the slot contents and the rotation pointer the unit holds no state, so no context needs saving when software switches tasks.

Top module: `cfu_dispatch`

## Requirements
- R1: After synchronous active-low reset every slot is invalid and the reload pointer `ld_slot` is 0, so the first request for any function number misses.
- R2: When `op_valid` is high and a valid slot holds a tag equal to `op_fn`, `res_valid` is 1, `miss` is 0 and `res_data` carries the slot's operation on `op_a`/`op_b`, all in the same cycle with no register in the path.
- R3: When `op_valid` is high and no valid slot matches, `miss` is 1, `res_valid` is 0 and `res_data` is 0; this holds for every cycle the request is held until a reload of the matching tag has taken effect.
- R4: When `op_valid` is low, `miss`, `res_valid` and `res_data` are all 0.
- R5: A cycle with `ld_valid` high writes `ld_tag` and `ld_sel` into slot `ld_slot`, marks it valid and advances `ld_slot` by one modulo 4; the new tag hits from the following cycle.
- R6: Replacement rotates through the slots, so the fifth reload after reset overwrites the first loaded tag, which then misses while the others keep hitting.
- R7: When more than one valid slot holds the requested tag, the slot with the lowest index supplies the operation.
- R8: Operation select encoding: 0 sum a+b, 1 difference a-b, 2 bitwise XOR, 3 bitwise AND, 4 rotate a left by b[4:0], 5 unsigned minimum, 6 bit-reversal of a, 7 count of ones in a; arithmetic wraps at 32 bits.
- R9: A request in the same cycle as a reload sees the slot contents from before that reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | A custom instruction is in the execute stage |
| op_fn | input | 11 | Requested function number |
| op_a | input | 32 | First source operand |
| op_b | input | 32 | Second source operand |
| ld_valid | input | 1 | Reload write strobe |
| ld_tag | input | 11 | Function number being loaded |
| ld_sel | input | 3 | Operation select bound to the loaded tag |
| res_valid | output | 1 | Result is valid (hit) |
| res_data | output | 32 | Result for the destination register |
| miss | output | 1 | Requested function not resident; stall or trap |
| ld_slot | output | 2 | Slot the next reload will write |

## Verification
A corrupted valid bit or tag shows up in the very cycle a request names that function: a spurious hit returns a result where `miss` was due, a lost slot raises `miss` for a function just loaded. A wrong stored select or a broken priority scan gives a wrong `res_data` on the same cycle, while a fault in the rotation pointer is visible on `ld_slot` one cycle after a reload and, within four reloads, as the wrong tag being evicted.

// File: rtl/cfu_pkg.sv
// Shared types for the custom function dispatch unit.
package cfu_pkg;
    // Built-in datapath operations a resident slot can bind to.
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_XOR  = 3'd2,
        OP_AND  = 3'd3,
        OP_ROTL = 3'd4,
        OP_MINU = 3'd5,
        OP_BREV = 3'd6,
        OP_POPC = 3'd7
    } fsel_e;
endpackage

// File: rtl/cfu_tag_store.sv
// Resident slot bank: valid bits, tags and operation selects, written in
// rotating order by the reload port and searched combinationally.
// Assumes: one reload per cycle at most; lowest matching index wins.
module cfu_tag_store
    import cfu_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int FN_W  = 11,
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [FN_W-1:0]  ld_tag,
    input  fsel_e            ld_sel,
    input  logic [FN_W-1:0]  lookup_fn,
    output logic             hit,
    output fsel_e            hit_sel,
    output logic [PTR_W-1:0] next_slot
);
    logic [SLOTS-1:0] valid_q;
    logic [FN_W-1:0]  tag_q [SLOTS];
    fsel_e            sel_q [SLOTS];
    logic [PTR_W-1:0] ptr_q;
    logic [SLOTS-1:0] match;

    // Rotation pointer: wraps after the last slot.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    // Clears validity on reset; writes the selected slot on a reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (ld_valid) begin
            valid_q[ptr_q] <= 1'b1;
            tag_q[ptr_q]   <= ld_tag;
            sel_q[ptr_q]   <= ld_sel;
            ptr_q          <= bump(ptr_q);
        end
    end

    // One comparator per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (tag_q[g] == lookup_fn);
    end

    // Priority pick: scan from the top so the lowest index is kept last.
    always_comb begin
        hit     = |match;
        hit_sel = OP_ADD;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) hit_sel = sel_q[i];
        end
    end

    assign next_slot = ptr_q;
endmodule

// File: rtl/cfu_func_unit.sv
// Combinational library of built-in operations, picked by the slot select.
// Assumes: XLEN is a power of two (rotate amount uses low log2 bits of b).
module cfu_func_unit
    import cfu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SH_W = $clog2(XLEN)
) (
    input  fsel_e            sel,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  y
);
    logic [2*XLEN-1:0] dbl;
    logic [XLEN-1:0]   rev;
    logic [XLEN-1:0]   ones;

    // Rotate by shifting a doubled copy and keeping the upper half.
    always_comb dbl = {a, a} << b[SH_W-1:0];

    // Mirror bit order and count set bits.
    always_comb begin
        ones = '0;
        for (int i = 0; i < XLEN; i++) begin
            rev[i] = a[XLEN-1-i];
            ones   = ones + {{(XLEN-1){1'b0}}, a[i]};
        end
    end

    // Output select.
    always_comb begin
        unique case (sel)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_XOR:  y = a ^ b;
            OP_AND:  y = a & b;
            OP_ROTL: y = dbl[2*XLEN-1:XLEN];
            OP_MINU: y = (a < b) ? a : b;
            OP_BREV: y = rev;
            OP_POPC: y = ones;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/cfu_dispatch.sv
// Execute-stage dispatch for custom instructions: checks the requested
// function number against resident tags, returns a same-cycle result on a
// hit and raises a miss otherwise. Assumes the host holds the request
// while miss is high and drives the reload port to resolve it.
module cfu_dispatch
    import cfu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int FN_W  = 11,
    parameter int SLOTS = 4,
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [FN_W-1:0]  op_fn,
    input  logic [XLEN-1:0]  op_a,
    input  logic [XLEN-1:0]  op_b,
    input  logic             ld_valid,
    input  logic [FN_W-1:0]  ld_tag,
    input  logic [2:0]       ld_sel,
    output logic             res_valid,
    output logic [XLEN-1:0]  res_data,
    output logic             miss,
    output logic [PTR_W-1:0] ld_slot
);
    logic            hit;
    fsel_e           hit_sel;
    logic [XLEN-1:0] fu_y;

    cfu_tag_store #(.SLOTS(SLOTS), .FN_W(FN_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_tag    (ld_tag),
        .ld_sel    (fsel_e'(ld_sel)),
        .lookup_fn (op_fn),
        .hit       (hit),
        .hit_sel   (hit_sel),
        .next_slot (ld_slot)
    );

    cfu_func_unit #(.XLEN(XLEN)) u_fu (
        .sel (hit_sel),
        .a   (op_a),
        .b   (op_b),
        .y   (fu_y)
    );

    // Qualify the lookup with the request and gate the result.
    always_comb begin
        res_valid = op_valid && hit;
        miss      = op_valid && !hit;
        res_data  = res_valid ? fu_y : '0;
    end
endmodule

// File: rtl/cfu_dispatch_chk.sv
// Port-level protocol checks for cfu_dispatch, bound onto every instance.
module cfu_dispatch_chk #(
    parameter int XLEN  = 32,
    parameter int FN_W  = 11,
    parameter int SLOTS = 4,
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [FN_W-1:0]  op_fn,
    input logic             ld_valid,
    input logic [FN_W-1:0]  ld_tag,
    input logic             res_valid,
    input logic [XLEN-1:0]  res_data,
    input logic             miss,
    input logic [PTR_W-1:0] ld_slot
);
    assert_first_use_misses_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !res_valid);

    assert_hit_miss_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && miss));

    assert_miss_zero_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (res_data == '0));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (!miss && !res_valid));

    assert_ptr_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (ld_slot == (($past(ld_slot) == PTR_W'(SLOTS - 1)) ? '0 : $past(ld_slot) + 1'b1)));

    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> $stable(ld_slot));

    assert_loaded_tag_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_valid) && op_valid && op_fn == $past(ld_tag)) |-> res_valid);
endmodule

bind cfu_dispatch cfu_dispatch_chk #(.XLEN(XLEN), .FN_W(FN_W), .SLOTS(SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_fn     (op_fn),
    .ld_valid  (ld_valid),
    .ld_tag    (ld_tag),
    .res_valid (res_valid),
    .res_data  (res_data),
    .miss      (miss),
    .ld_slot   (ld_slot)
);

// File: tb/sim_cfu_dispatch.sv
`timescale 1ns/1ps
module sim_cfu_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [10:0] op_fn = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        ld_valid = 1'b0;
    logic [10:0] ld_tag = '0;
    logic [2:0]  ld_sel = '0;
    logic        res_valid, miss;
    logic [31:0] res_data;
    logic [1:0]  ld_slot;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cfu_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_fn(op_fn),
        .op_a(op_a), .op_b(op_b), .ld_valid(ld_valid), .ld_tag(ld_tag),
        .ld_sel(ld_sel), .res_valid(res_valid), .res_data(res_data),
        .miss(miss), .ld_slot(ld_slot)
    );

    // Expected result from the select encoding of R8.
    function automatic logic [31:0] model(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        int k;
        case (s)
            3'd0: r = a + b;
            3'd1: r = a - b;
            3'd2: r = a ^ b;
            3'd3: r = a & b;
            3'd4: begin k = int'(b[4:0]); r = (k == 0) ? a : ((a << k) | (a >> (32 - k))); end
            3'd5: r = (a <= b) ? a : b;
            3'd6: begin r = '0; for (int i = 0; i < 32; i++) r[31-i] = a[i]; end
            default: begin r = '0; for (int i = 0; i < 32; i++) if (a[i]) r = r + 1; end
        endcase
        return r;
    endfunction

    task automatic expect_out(input string req, input logic ev, input logic em, input logic [31:0] ed);
        n_chk++;
        if (res_valid !== ev || miss !== em || res_data !== ed) begin
            n_bad++;
            $display("FAIL %s: valid/miss/data = %0b/%0b/%h expected %0b/%0b/%h",
                     req, res_valid, miss, res_data, ev, em, ed);
        end
    endtask

    task automatic expect_slot(input string req, input logic [1:0] e);
        n_chk++;
        if (ld_slot !== e) begin
            n_bad++;
            $display("FAIL %s: ld_slot = %0d expected %0d", req, ld_slot, e);
        end
    endtask

    task automatic apply(input logic [10:0] fn, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_fn = fn; op_a = a; op_b = b;
        #1;
    endtask

    task automatic reload(input logic [10:0] t, input logic [2:0] s);
        @(negedge clk);
        op_valid = 1'b0;
        ld_valid = 1'b1; ld_tag = t; ld_sel = s;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0; ld_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    typedef struct packed {
        logic [10:0] fn;
        logic [31:0] a;
        logic [31:0] b;
        logic        hit;
        logic [2:0]  sel;
    } vec_t;

    // Slots after the first four reloads: 001 sum, 7FF xor, 155 rotate, 2AA popcount.
    localparam vec_t VECS [10] = '{
        '{11'h001, 32'hFFFF_FFFF, 32'h0000_0002, 1'b1, 3'd0},
        '{11'h001, 32'h1234_5678, 32'h1111_1111, 1'b1, 3'd0},
        '{11'h7FF, 32'hA5A5_A5A5, 32'hFFFF_0000, 1'b1, 3'd2},
        '{11'h155, 32'h8000_0001, 32'h0000_0004, 1'b1, 3'd4},
        '{11'h155, 32'hDEAD_BEEF, 32'h0000_0020, 1'b1, 3'd4},
        '{11'h155, 32'h0000_0001, 32'h0000_001F, 1'b1, 3'd4},
        '{11'h2AA, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 3'd7},
        '{11'h2AA, 32'h0000_0000, 32'h1234_0000, 1'b1, 3'd7},
        '{11'h000, 32'h0000_0005, 32'h0000_0006, 1'b0, 3'd0},
        '{11'h400, 32'h0000_0005, 32'h0000_0006, 1'b0, 3'd0}
    };

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        expect_slot("R1 pointer after reset", 2'd0);
        expect_out("R4 idle after reset", 1'b0, 1'b0, 32'h0);
        apply(11'h001, 32'd1, 32'd2);
        expect_out("R1 first use misses", 1'b0, 1'b1, 32'h0);
        apply(11'h7FF, 32'd1, 32'd2);
        expect_out("R1 first use misses", 1'b0, 1'b1, 32'h0);

        reload(11'h001, 3'd0);
        expect_slot("R5 pointer advances", 2'd1);
        reload(11'h7FF, 3'd2);
        reload(11'h155, 3'd4);
        reload(11'h2AA, 3'd7);
        expect_slot("R5 pointer wraps", 2'd0);

        // Table walk: hits and misses across all loaded operations (R2, R3, R8).
        for (int v = 0; v < 10; v++) begin
            apply(VECS[v].fn, VECS[v].a, VECS[v].b);
            if (VECS[v].hit)
                expect_out("R2/R8 table hit", 1'b1, 1'b0, model(VECS[v].sel, VECS[v].a, VECS[v].b));
            else
                expect_out("R3 table miss", 1'b0, 1'b1, 32'h0);
        end

        // Fifth reload evicts slot 0 (R6).
        reload(11'h0F0, 3'd1);
        apply(11'h001, 32'd9, 32'd9);
        expect_out("R6 evicted tag misses", 1'b0, 1'b1, 32'h0);
        apply(11'h7FF, 32'h0F0F_0F0F, 32'h00FF_00FF);
        expect_out("R6 survivor still hits", 1'b1, 1'b0, 32'h0FF0_0FF0);
        apply(11'h0F0, 32'd5, 32'd7);
        expect_out("R6 new tag hits", 1'b1, 1'b0, 32'hFFFF_FFFE);

        // Held miss persists, reload in same cycle is not yet visible (R3, R9).
        apply(11'h333, 32'h0000_0040, 32'h0000_0030);
        for (int c = 0; c < 3; c++) begin
            expect_out("R3 miss held", 1'b0, 1'b1, 32'h0);
            @(negedge clk); #1;
        end
        ld_valid = 1'b1; ld_tag = 11'h333; ld_sel = 3'd5;
        #1;
        expect_out("R9 same-cycle reload not visible", 1'b0, 1'b1, 32'h0);
        @(negedge clk);
        ld_valid = 1'b0;
        #1;
        expect_out("R5 loaded tag hits next cycle", 1'b1, 1'b0, 32'h0000_0030);
        apply(11'h7FF, 32'd1, 32'd1);
        expect_out("R6 second eviction misses", 1'b0, 1'b1, 32'h0);

        // Duplicate tags: lowest slot wins (R7).
        do_reset();
        expect_slot("R1 pointer after second reset", 2'd0);
        apply(11'h155, 32'd1, 32'd1);
        expect_out("R1 slots cleared by reset", 1'b0, 1'b1, 32'h0);
        reload(11'h0AA, 3'd0);
        reload(11'h0AA, 3'd1);
        apply(11'h0AA, 32'd10, 32'd3);
        expect_out("R7 lowest slot wins", 1'b1, 1'b0, 32'd13);
        reload(11'h011, 3'd3);
        reload(11'h022, 3'd6);
        reload(11'h0BB, 3'd2);
        apply(11'h0AA, 32'd10, 32'd3);
        expect_out("R7 next slot takes over", 1'b1, 1'b0, 32'd7);
        apply(11'h022, 32'h0000_0003, 32'd0);
        expect_out("R8 bit reverse", 1'b1, 1'b0, 32'hC000_0000);
        apply(11'h011, 32'hF0F0_1234, 32'h0FF0_FFFF);
        expect_out("R8 and", 1'b1, 1'b0, 32'h00F0_1234);
        apply(11'h0BB, 32'h0000_0000, 32'h1357_9BDF);
        expect_out("R8 xor", 1'b1, 1'b0, 32'h1357_9BDF);

        @(negedge clk);
        op_valid = 1'b0; op_fn = 11'h0AA;
        #1;
        expect_out("R4 idle with matching tag", 1'b0, 1'b0, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule